// File: doc/BRIEF.md
# Eight-Bit Logic and Arithmetic Unit with Signed-Distance Shifter

This block is the purely combinational datapath of a small register machine. It takes two 8-bit operands and a 4-bit operation code and produces an 8-bit result in the same cycle, together with a flag that goes high when that result is all zeros. The processor's branch step uses that flag.

The supported operations are bitwise AND, OR and XOR of the two operands, inversion of the first operand, and two's-complement addition that drops the final carry. The adder is built as a ripple of explicit full-adder columns. Software subtracts by adding the inverted and incremented second value. The shift operation reads the second operand as a signed distance. A positive value moves the first operand toward bit 0 and a negative value moves it toward bit 7. Vacated positions always take zeros.

The operation code uses the processor's own instruction numbering. Codes that belong to control instructions (memory transfer, branch, stop) are not arithmetic, so they yield a zero result.

Top module: `bitops_alu`

## Requirements
- R1: Code 9 gives a AND b, code 8 gives a OR b, code 7 gives a XOR b, each bit by bit.
- R2: Code 2 gives the bitwise inverse of a, whatever b is (for example 0x68 gives 0x97).
- R3: Code 6 gives (a + b) mod 256 with the carry out discarded, so adding 7 and 0xFD (the negation of 3) gives 0x04.
- R4: Code 1 with b read as a two's-complement value from 1 to 7 shifts a right by b places, and zeros enter at bit 7.
- R5: Code 1 with b from -1 to -7 shifts a left by -b places, and zeros enter at bit 0.
- R6: Code 1 with b equal to 0 passes a through unchanged, and with a signed magnitude of 8 or more (including -128) it gives 0.
- R7: Code 1 with b equal to 7 leaves the old bit 7 of a in bit 0, with all other bits zero.
- R8: Codes 0, 3, 4, 5 and 10 through 15 give a result of 0.
- R9: zero_o is high exactly when the 8-bit result is 0, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (processor instruction numbering) |
| a_i | input | 8 | First operand; the value being shifted or inverted |
| b_i | input | 8 | Second operand; a signed distance for shifts |
| res_o | output | 8 | Operation result |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The embedded assertions check several things on every evaluation. The ripple chain matches the arithmetic sum modulo 256. A zero distance passes a through. A distance of seven isolates the old sign bit. Zeros fill the vacated end for both directions. Inversion complements every bit, AND clears every bit that b lacks, and control codes give zero. The exact placement of bits under every shift distance, the wrap-around of addition and subtraction, and the zero flag across all codes are shown only by the bench. It sweeps all 16 codes over every first operand and a dense spread of second operands, including the extremes ±7, ±8 and -128, and compares each result to an arithmetic model.

// File: rtl/bitops_alu_pkg.sv
package bitops_alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] OPC_SHIFT = 4'd1;
  localparam logic [CODE_W-1:0] OPC_INV   = 4'd2;
  localparam logic [CODE_W-1:0] OPC_SUM   = 4'd6;
  localparam logic [CODE_W-1:0] OPC_XOR   = 4'd7;
  localparam logic [CODE_W-1:0] OPC_OR    = 4'd8;
  localparam logic [CODE_W-1:0] OPC_AND   = 4'd9;
endpackage

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_col
    logic half;
    assign half         = x_i[k] ^ y_i[k];
    assign sum_o[k]     = half ^ carry[k];
    assign carry[k+1]   = (half & carry[k]) | (x_i[k] & y_i[k]);
  end

  // R3: gate-level chain agrees with arithmetic sum modulo 2^W
  always_comb begin
    assert_sum_modulo_R3: assert (sum_o == W'(x_i + y_i))
      else $error("ripple sum mismatch");
  end
endmodule

// File: rtl/signed_shift.sv
module signed_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] dist_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W:0]  LIMIT = (W+1)'(W);

  logic          leftward;
  logic [W-1:0]  mag;
  logic          in_range;
  logic [IW-1:0] steps;

  always_comb begin
    leftward = dist_i[W-1];
    mag      = leftward ? (~dist_i + 1'b1) : dist_i;
    in_range = ({1'b0, mag} < LIMIT);
    steps    = mag[IW-1:0];
    if (!in_range)     res_o = '0;
    else if (leftward) res_o = val_i << steps;
    else               res_o = val_i >> steps;
  end

  always_comb begin
    // R6: zero distance is a pass-through
    assert_zero_dist_pass_R6: assert (!(dist_i == '0) || res_o == val_i)
      else $error("zero distance altered value");
    // R7: distance W-1 leaves only the old top bit at position 0
    assert_sign_isolate_R7: assert (!(dist_i == W'(W-1)) ||
                                    res_o == {{(W-1){1'b0}}, val_i[W-1]})
      else $error("sign isolation failed");
    // R4: a rightward move puts a zero in the top position
    assert_right_fill_R4: assert (!(!dist_i[W-1] && dist_i != '0) || !res_o[W-1])
      else $error("right shift fill not zero");
    // R5: a leftward move puts a zero in the bottom position
    assert_left_fill_R5: assert (!dist_i[W-1] || !res_o[0])
      else $error("left shift fill not zero");
  end
endmodule

// File: rtl/bitops_alu.sv
module bitops_alu
  import bitops_alu_pkg::*;
(
  input  logic [CODE_W-1:0] op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] shift_w;

  ripple_add #(.W(DATA_W)) adder_i (
    .x_i   (a_i),
    .y_i   (b_i),
    .sum_o (sum_w)
  );

  signed_shift #(.W(DATA_W)) shifter_i (
    .val_i  (a_i),
    .dist_i (b_i),
    .res_o  (shift_w)
  );

  always_comb begin
    case (op_i)
      OPC_AND:   res_o = a_i & b_i;
      OPC_OR:    res_o = a_i | b_i;
      OPC_XOR:   res_o = a_i ^ b_i;
      OPC_INV:   res_o = ~a_i;
      OPC_SUM:   res_o = sum_w;
      OPC_SHIFT: res_o = shift_w;
      default:   res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;

  logic is_alu_code;
  assign is_alu_code = (op_i == OPC_AND) || (op_i == OPC_OR) || (op_i == OPC_XOR) ||
                       (op_i == OPC_INV) || (op_i == OPC_SUM) || (op_i == OPC_SHIFT);

  always_comb begin
    // R8: control codes yield nothing
    assert_ctrl_code_zero_R8: assert (is_alu_code || (res_o == '0 && zero_o))
      else $error("control code produced data");
    // R2: inversion complements every bit of a
    assert_inv_complete_R2: assert (op_i != OPC_INV || (res_o ^ a_i) == '1)
      else $error("inversion incomplete");
    // R1: AND never sets a bit absent from b
    assert_and_masked_R1: assert (op_i != OPC_AND || (res_o & ~b_i) == '0)
      else $error("AND leaked bits");
  end
endmodule

// File: tb/bitops_alu_tb.sv
module bitops_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk;
  logic [3:0] op;
  logic [7:0] a, b;
  logic [7:0] res;
  logic       zero;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  bitops_alu dut_i (.op_i(op), .a_i(a), .b_i(b), .res_o(res), .zero_o(zero));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model(input logic [3:0] o, input logic [7:0] x,
                                       input logic [7:0] y);
    int s;
    case (o)
      4'd9: return x & y;
      4'd8: return x | y;
      4'd7: return x ^ y;
      4'd2: return ~x;
      4'd6: return 8'((int'(x) + int'(y)) % 256);
      4'd1: begin
        s = int'($signed(y));
        if (s >= 8 || s <= -8) return 8'd0;
        if (s >= 0) return 8'((int'(x) / (1 << s)));
        return 8'((int'(x) * (1 << (-s))) % 256);
      end
      default: return 8'd0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] o, input logic [7:0] y);
    int s;
    case (o)
      4'd9, 4'd8, 4'd7: return "R1";
      4'd2: return "R2";
      4'd6: return "R3";
      4'd1: begin
        s = int'($signed(y));
        if (s == 7) return "R7";
        if (s == 0 || s >= 8 || s <= -8) return "R6";
        if (s > 0) return "R4";
        return "R5";
      end
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input string req);
    logic [7:0] exp_r;
    op = o; a = x; b = y;
    #1;
    exp_r = model(o, x, y);
    checks++;
    if (res !== exp_r) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h res actual=%02h expected=%02h",
               req, o, x, y, res, exp_r);
    end
    checks++;
    if (zero !== (exp_r == 8'd0)) begin
      failures++;
      $display("FAIL R9 op=%0d a=%02h b=%02h zero actual=%0b expected=%0b",
               o, x, y, zero, (exp_r == 8'd0));
    end
  endtask

  initial begin
    op = 4'd0; a = 8'd0; b = 8'd0;
    #(CLK_PERIOD/2 + 1);
    // idle state: control code, zero operands -> R8, R9
    apply(4'd0, 8'h00, 8'h00, "R8");
    // directed corners
    apply(4'd6, 8'h07, 8'hFD, "R3");   // 7 - 3 = 4
    apply(4'd6, 8'hFF, 8'h01, "R3");   // carry dropped -> 0
    apply(4'd2, 8'h68, 8'hAA, "R2");   // 0x68 -> 0x97
    apply(4'd1, 8'h80, 8'h07, "R7");
    apply(4'd1, 8'h6C, 8'h07, "R7");
    apply(4'd1, 8'hB5, 8'h80, "R6");   // -128
    apply(4'd1, 8'hB5, 8'h08, "R6");
    apply(4'd1, 8'hB5, 8'hF8, "R6");   // -8
    apply(4'd1, 8'hB5, 8'hF9, "R5");   // -7
    apply(4'd1, 8'hB5, 8'h00, "R6");
    apply(4'd1, 8'h6C, 8'h01, "R4");
    apply(4'd1, 8'h6C, 8'hFE, "R5");   // -2
    apply(4'd9, 8'hB6, 8'h68, "R1");
    apply(4'd8, 8'hB6, 8'h68, "R1");
    apply(4'd7, 8'hB6, 8'h68, "R1");
    apply(4'd4, 8'hFF, 8'hFF, "R8");
    // sweep: every code, every a, spread of b plus shift extremes
    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y += 9) apply(4'(o), 8'(x), 8'(y), tag(4'(o), 8'(y)));
        if (o == 1) begin
          for (int y = -9; y <= 9; y++) apply(4'(o), 8'(x), 8'(y), tag(4'(o), 8'(y)));
          apply(4'(o), 8'(x), 8'h80, "R6");
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < WATCHDOG_CYCLES; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule